// File: doc/BRIEF.md
# Oversampling Serial Receiver with Flagged Receive FIFO

This block turns an asynchronous serial line into parallel characters. A free-running enable pulse at sixteen times the bit rate paces all sampling. The receiver checks a falling edge at the middle of the start bit and throws away glitches that do not last that long. It then collects 5 to 8 data bits with the least significant bit first, an optional parity bit and one stop bit. Each finished character is written into a 16-deep receive FIFO, and every entry carries three error flags: parity error, framing error and line break.

The host sees the oldest entry directly on the read outputs and removes it with a one-cycle pop. It also sees the fill level, a data-ready flag, a sticky overrun flag and a data-available flag. Data-available goes high once the fill level reaches a threshold the host selects. The serial input goes through a two-stage synchroniser before the sampling logic sees it. Character length and parity mode are expected to stay unchanged while a character is being received.

Top module: `async_rx_core`

## Requirements
- R1: When the synchronised line falls from high to low on a tick, the start bit is confirmed only if the line is still low 8 ticks later. If it is high at that point, the event is dropped, nothing is stored, and the receiver returns to idle.
- R2: After a confirmed start, each data bit is sampled 16 ticks after the previous sample point, least significant bit first. `char_len_i` values 0, 1, 2 and 3 select 5, 6, 7 and 8 bits, and the unused upper data bits are stored as zero.
- R3: `parity_i` selects 00 none, 01 even, 10 odd, 11 none. When parity is enabled, one parity bit follows the data. The parity flag (`rd_perr_o`) is set when the number of ones in the data bits plus the parity bit is odd in even mode, or even in odd mode.
- R4: If the stop sample is low and the character is not a break, the character is stored with the framing flag (`rd_ferr_o`) set. The receiver then waits for the line to go high before it accepts a new falling edge.
- R5: If every data bit, the parity bit (when enabled) and the stop bit are all sampled low, exactly one entry is stored with data 0x00, `rd_brk_o`=1 and both other flags clear. No further character starts until the line has returned high.
- R6: The FIFO holds 16 entries in arrival order. The read outputs show the oldest entry while `level_o` is nonzero. A pop removes that entry, and a pop while the FIFO is empty changes nothing.
- R7: If a character completes while 16 entries are held, that character is dropped, the stored entries stay unchanged, and `overrun_o` is set. It stays set until a `status_rd_i` pulse, and a new overrun in the same cycle wins over the clear.
- R8: `data_ready_o` is high exactly when `level_o` is nonzero.
- R9: `data_avail_o` is high exactly when `level_o` is at or above the threshold chosen by `thresh_sel_i`: 0→1, 1→4, 2→8, 3→14.
- R10: The line is sampled only on clocks where `tick16_i` is high. `rxd_i` passes through two synchronising flops. A completed character appears in `level_o` one clock after its stop sample.
- R11: After reset the FIFO is empty, `overrun_o` is low and the receiver is idle, with the line taken as high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tick16_i | input | 1 | Enable pulse at 16x bit rate |
| rxd_i | input | 1 | Asynchronous serial input, idle high |
| char_len_i | input | 2 | Data bits minus five |
| parity_i | input | 2 | Parity mode select |
| thresh_sel_i | input | 2 | Data-available threshold select |
| pop_i | input | 1 | Remove the oldest FIFO entry |
| status_rd_i | input | 1 | Clear the overrun flag |
| rd_data_o | output | 8 | Oldest entry data byte |
| rd_perr_o | output | 1 | Oldest entry parity error |
| rd_ferr_o | output | 1 | Oldest entry framing error |
| rd_brk_o | output | 1 | Oldest entry break flag |
| level_o | output | 5 | FIFO fill level |
| data_ready_o | output | 1 | FIFO not empty |
| data_avail_o | output | 1 | Fill level at or above threshold |
| overrun_o | output | 1 | Sticky overrun flag |

## Verification
If the tick counter or the bit index goes wrong, the receiver samples at the wrong place in the frame. That shows up as a wrong byte or a wrong flag at the FIFO head within one character time. It can also show up as a `level_o` change a few ticks early or late, and the per-clock comparison catches that in the same cycle.

A pointer or count fault in the FIFO shows on `level_o`, `data_ready_o` or the head entry on the next clock. A bad sticky overrun flag shows on the cycle after the push that should have set it, or after the read that should have cleared it.

// File: rtl/async_rx_pkg.sv
package async_rx_pkg;

    localparam int OVS        = 16;
    localparam int DATA_W     = 8;
    localparam int FIFO_DEPTH = 16;
    localparam int MIN_BITS   = 5;

    typedef enum logic [1:0] {
        PAR_NONE     = 2'b00,
        PAR_EVEN     = 2'b01,
        PAR_ODD      = 2'b10,
        PAR_NONE_ALT = 2'b11
    } par_mode_e;

    typedef enum logic [2:0] {
        RX_IDLE,
        RX_START,
        RX_DATA,
        RX_PARITY,
        RX_STOP,
        RX_BRKWAIT
    } rx_state_e;

    typedef struct packed {
        logic              brk;
        logic              frm_err;
        logic              par_err;
        logic [DATA_W-1:0] data;
    } rx_entry_t;

    function automatic logic [3:0] char_bits(input logic [1:0] code);
        return 4'(MIN_BITS) + {2'b00, code};
    endfunction

    function automatic logic [4:0] fill_mark(input logic [1:0] sel);
        case (sel)
            2'd0:    return 5'd1;
            2'd1:    return 5'd4;
            2'd2:    return 5'd8;
            default: return 5'd14;
        endcase
    endfunction

    function automatic logic par_enabled(input par_mode_e m);
        return (m == PAR_EVEN) || (m == PAR_ODD);
    endfunction

endpackage

// File: rtl/rx_line_sync.sv
module rx_line_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic d_i,
    output logic q_o
);
    logic [STAGES-1:0] chain;

    generate
        for (genvar g = 0; g < STAGES; g++) begin : g_stage
            if (g == 0) begin : g_first
                always_ff @(posedge clk) begin
                    if (rst) chain[0] <= 1'b1;
                    else     chain[0] <= d_i;
                end
            end else begin : g_next
                always_ff @(posedge clk) begin
                    if (rst) chain[g] <= 1'b1;
                    else     chain[g] <= chain[g-1];
                end
            end
        end
    endgenerate

    assign q_o = chain[STAGES-1];
endmodule

// File: rtl/rx_sampler.sv
module rx_sampler
    import async_rx_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  logic      tick_i,
    input  logic      rx_i,
    input  logic [1:0] len_i,
    input  logic [1:0] par_i,
    output logic      push_o,
    output rx_entry_t entry_o
);
    localparam int CW = $clog2(OVS);
    localparam logic [CW-1:0] MID_CNT  = CW'(OVS/2 - 1);
    localparam logic [CW-1:0] FULL_CNT = CW'(OVS - 1);

    rx_state_e         state;
    logic [CW-1:0]     tcnt;
    logic [2:0]        bit_idx;
    logic [DATA_W-1:0] shreg;
    logic              pbit;
    logic              prev;

    par_mode_e pm;
    logic      par_on;
    logic      last_bit;
    logic      all_low;
    logic      par_bad;

    assign pm       = par_mode_e'(par_i);
    assign par_on   = par_enabled(pm);
    assign last_bit = ({1'b0, bit_idx} == (char_bits(len_i) - 4'd1));
    assign all_low  = (shreg == '0) && !(par_on && pbit) && !rx_i;
    assign par_bad  = par_on && ((^shreg) ^ pbit ^ (pm == PAR_ODD));

    always_ff @(posedge clk) begin
        if (rst) begin
            state   <= RX_IDLE;
            tcnt    <= '0;
            bit_idx <= '0;
            shreg   <= '0;
            pbit    <= 1'b0;
            prev    <= 1'b1;
            push_o  <= 1'b0;
            entry_o <= '0;
        end else begin
            push_o <= 1'b0;
            if (tick_i) begin
                prev <= rx_i;
                case (state)
                    RX_IDLE: begin
                        if (prev && !rx_i) begin
                            state <= RX_START;
                            tcnt  <= '0;
                        end
                    end
                    RX_START: begin
                        if (tcnt == MID_CNT) begin
                            tcnt    <= '0;
                            bit_idx <= '0;
                            shreg   <= '0;
                            pbit    <= 1'b0;
                            state   <= rx_i ? RX_IDLE : RX_DATA;
                        end else begin
                            tcnt <= tcnt + 1'b1;
                        end
                    end
                    RX_DATA: begin
                        if (tcnt == FULL_CNT) begin
                            tcnt           <= '0;
                            shreg[bit_idx] <= rx_i;
                            if (last_bit) state <= par_on ? RX_PARITY : RX_STOP;
                            else          bit_idx <= bit_idx + 1'b1;
                        end else begin
                            tcnt <= tcnt + 1'b1;
                        end
                    end
                    RX_PARITY: begin
                        if (tcnt == FULL_CNT) begin
                            tcnt  <= '0;
                            pbit  <= rx_i;
                            state <= RX_STOP;
                        end else begin
                            tcnt <= tcnt + 1'b1;
                        end
                    end
                    RX_STOP: begin
                        if (tcnt == FULL_CNT) begin
                            tcnt   <= '0;
                            push_o <= 1'b1;
                            if (all_low) begin
                                entry_o <= '{brk: 1'b1, frm_err: 1'b0,
                                             par_err: 1'b0, data: '0};
                                state   <= RX_BRKWAIT;
                            end else begin
                                entry_o <= '{brk: 1'b0, frm_err: !rx_i,
                                             par_err: par_bad, data: shreg};
                                state   <= RX_IDLE;
                            end
                        end else begin
                            tcnt <= tcnt + 1'b1;
                        end
                    end
                    RX_BRKWAIT: begin
                        if (rx_i) state <= RX_IDLE;
                    end
                    default: state <= RX_IDLE;
                endcase
            end
        end
    end

    // R5
    brk_zero_chk: assert property (@(posedge clk) disable iff (rst)
        (push_o && entry_o.brk) |-> (entry_o.data == '0 && !entry_o.frm_err && !entry_o.par_err));

    // R10
    tick_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !tick_i |=> $stable(state) && $stable(tcnt));

endmodule

// File: rtl/rx_fifo.sv
module rx_fifo
    import async_rx_pkg::*;
#(
    parameter int DEPTH = FIFO_DEPTH
) (
    input  logic                       clk,
    input  logic                       rst,
    input  logic                       push_i,
    input  rx_entry_t                  wdata_i,
    input  logic                       pop_i,
    output rx_entry_t                  head_o,
    output logic [$clog2(DEPTH+1)-1:0] count_o,
    output logic                       full_o
);
    localparam int AW = $clog2(DEPTH);
    localparam int CW = $clog2(DEPTH+1);

    rx_entry_t     mem [DEPTH];
    logic [AW-1:0] wptr, rptr;
    logic [CW-1:0] count;
    logic          wr_en, rd_en, empty;

    assign full_o  = (count == CW'(DEPTH));
    assign empty   = (count == '0);
    assign wr_en   = push_i && !full_o;
    assign rd_en   = pop_i && !empty;
    assign head_o  = mem[rptr];
    assign count_o = count;

    function automatic logic [AW-1:0] bump(input logic [AW-1:0] p);
        return (p == AW'(DEPTH-1)) ? '0 : p + 1'b1;
    endfunction

    always_ff @(posedge clk) begin
        if (wr_en) mem[wptr] <= wdata_i;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            wptr  <= '0;
            rptr  <= '0;
            count <= '0;
        end else begin
            if (wr_en) wptr <= bump(wptr);
            if (rd_en) rptr <= bump(rptr);
            count <= count + CW'(wr_en) - CW'(rd_en);
        end
    end

    // R6
    no_overflow_chk: assert property (@(posedge clk) disable iff (rst)
        count <= CW'(DEPTH));

    // R6
    empty_pop_chk: assert property (@(posedge clk) disable iff (rst)
        (pop_i && empty && !push_i) |=> (count == '0));

    // R7
    full_keep_chk: assert property (@(posedge clk) disable iff (rst)
        (push_i && full_o && !pop_i) |=> (full_o && $stable(rptr)));

endmodule

// File: rtl/async_rx_core.sv
module async_rx_core
    import async_rx_pkg::*;
#(
    parameter int DEPTH       = FIFO_DEPTH,
    parameter int SYNC_STAGES = 2,
    localparam int LVL_W      = $clog2(DEPTH+1)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             tick16_i,
    input  logic             rxd_i,
    input  logic [1:0]       char_len_i,
    input  logic [1:0]       parity_i,
    input  logic [1:0]       thresh_sel_i,
    input  logic             pop_i,
    input  logic             status_rd_i,
    output logic [7:0]       rd_data_o,
    output logic             rd_perr_o,
    output logic             rd_ferr_o,
    output logic             rd_brk_o,
    output logic [LVL_W-1:0] level_o,
    output logic             data_ready_o,
    output logic             data_avail_o,
    output logic             overrun_o
);
    logic      rx_s;
    logic      rx_push;
    rx_entry_t rx_entry;
    rx_entry_t head;
    logic      fifo_full;

    rx_line_sync #(.STAGES(SYNC_STAGES)) i_sync (
        .clk (clk),
        .rst (rst),
        .d_i (rxd_i),
        .q_o (rx_s)
    );

    rx_sampler i_sampler (
        .clk     (clk),
        .rst     (rst),
        .tick_i  (tick16_i),
        .rx_i    (rx_s),
        .len_i   (char_len_i),
        .par_i   (parity_i),
        .push_o  (rx_push),
        .entry_o (rx_entry)
    );

    rx_fifo #(.DEPTH(DEPTH)) i_fifo (
        .clk     (clk),
        .rst     (rst),
        .push_i  (rx_push),
        .wdata_i (rx_entry),
        .pop_i   (pop_i),
        .head_o  (head),
        .count_o (level_o),
        .full_o  (fifo_full)
    );

    always_ff @(posedge clk) begin
        if (rst)                       overrun_o <= 1'b0;
        else if (rx_push && fifo_full) overrun_o <= 1'b1;
        else if (status_rd_i)          overrun_o <= 1'b0;
    end

    assign rd_data_o    = head.data;
    assign rd_perr_o    = head.par_err;
    assign rd_ferr_o    = head.frm_err;
    assign rd_brk_o     = head.brk;
    assign data_ready_o = (level_o != '0);
    assign data_avail_o = ({{(8-LVL_W){1'b0}}, level_o} >= {3'b000, fill_mark(thresh_sel_i)});

    // R7
    ovr_set_chk: assert property (@(posedge clk) disable iff (rst)
        (rx_push && fifo_full) |=> overrun_o);

    // R7
    ovr_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (overrun_o && !status_rd_i) |=> overrun_o);

endmodule

// File: tb/test_async_rx_core.sv
module test_async_rx_core;
    localparam int CLK_PERIOD = 10;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       tick16 = 1'b0;
    logic       rxd = 1'b1;
    logic [1:0] len_code = 2'd3;
    logic [1:0] par_mode = 2'd0;
    logic [1:0] thr_sel = 2'd0;
    logic       pop = 1'b0;
    logic       stat_rd = 1'b0;

    logic [7:0] rd_data;
    logic       rd_perr, rd_ferr, rd_brk;
    logic [4:0] level;
    logic       data_ready, data_avail, overrun;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    async_rx_core i_async_rx_core (
        .clk(clk), .rst(rst), .tick16_i(tick16), .rxd_i(rxd),
        .char_len_i(len_code), .parity_i(par_mode), .thresh_sel_i(thr_sel),
        .pop_i(pop), .status_rd_i(stat_rd),
        .rd_data_o(rd_data), .rd_perr_o(rd_perr), .rd_ferr_o(rd_ferr), .rd_brk_o(rd_brk),
        .level_o(level), .data_ready_o(data_ready), .data_avail_o(data_avail),
        .overrun_o(overrun)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    // tick generator
    int tick_div = 1;
    int tdc = 0;
    always @(negedge clk) begin
        if (tdc >= tick_div - 1) begin tdc <= 0; tick16 <= 1'b1; end
        else begin tdc <= tdc + 1; tick16 <= 1'b0; end
    end

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s actual=%0h expected=%0h at %0t", req, what, act, exp, $time);
        end
    endtask

    // behavioural reference: queue of {brk,ferr,perr,data}
    bit [10:0] mq[$];
    bit        m_s1 = 1, m_s2 = 1, m_line, m_prev = 1;
    int        m_mode = 0;     // 0 idle, 1 in frame, 2 waiting after break
    int        m_age = 0;
    int        m_nb, m_k;
    bit [7:0]  m_dat;
    bit        m_pb;
    bit        m_pend = 0, m_np;
    bit [10:0] m_pv, m_nv;
    bit        m_ovr = 0, m_full, m_pon, m_bad;

    always @(posedge clk) begin
        if (rst) begin
            mq.delete();
            m_s1 = 1; m_s2 = 1; m_prev = 1; m_mode = 0; m_pend = 0; m_ovr = 0;
        end else begin
            m_full = (mq.size() == 16);
            if (pop && mq.size() > 0) void'(mq.pop_front());
            if (m_pend && !m_full) mq.push_back(m_pv);
            if (m_pend && m_full) m_ovr = 1;
            else if (stat_rd) m_ovr = 0;
            m_np = 0;
            if (tick16) begin
                m_line = m_s2;
                m_nb   = 5 + int'(len_code);
                m_pon  = (par_mode == 2'd1) || (par_mode == 2'd2);
                if (m_mode == 0) begin
                    if (m_prev && !m_line) begin m_mode = 1; m_age = 0; m_dat = 0; m_pb = 0; end
                end else if (m_mode == 1) begin
                    m_age++;
                    if (m_age % 16 == 8) begin
                        m_k = (m_age - 8) / 16;
                        if (m_k == 0) begin
                            if (m_line) m_mode = 0;
                        end else if (m_k <= m_nb) begin
                            m_dat[m_k-1] = m_line;
                        end else if (m_pon && m_k == m_nb + 1) begin
                            m_pb = m_line;
                        end else begin
                            m_np = 1;
                            if (m_dat == 0 && !(m_pon && m_pb) && !m_line) begin
                                m_nv = {3'b100, 8'h00};
                                m_mode = 2;
                            end else begin
                                m_bad = m_pon && ((^m_dat) ^ m_pb ^ (par_mode == 2'd2));
                                m_nv = {1'b0, !m_line, m_bad, m_dat};
                                m_mode = 0;
                            end
                        end
                    end
                end else begin
                    if (m_line) m_mode = 0;
                end
                m_prev = m_line;
            end
            m_pend = m_np;
            m_pv   = m_nv;
            m_s2 = m_s1;
            m_s1 = rxd;
        end
    end

    int thr;
    always @(negedge clk) begin
        if (!rst && !done) begin
            chk(level == 5'(mq.size()), "R6", "level", level, mq.size());
            chk(data_ready == (mq.size() != 0), "R8", "data_ready", data_ready, mq.size() != 0);
            case (thr_sel) 2'd0: thr = 1; 2'd1: thr = 4; 2'd2: thr = 8; default: thr = 14; endcase
            chk(data_avail == (mq.size() >= thr), "R9", "data_avail", data_avail, mq.size() >= thr);
            chk(overrun == m_ovr, "R7", "overrun", overrun, m_ovr);
            if (mq.size() > 0)
                chk({rd_brk, rd_ferr, rd_perr, rd_data} == mq[0], "R2", "head entry",
                    {rd_brk, rd_ferr, rd_perr, rd_data}, mq[0]);
        end
    end

    task automatic bit_time(input bit v);
        rxd = v;
        repeat (16 * tick_div) @(negedge clk);
    endtask

    task automatic send(input bit [7:0] d, input bit stopv, input bit flip);
        int n;
        bit p;
        n = 5 + int'(len_code);
        bit_time(1'b0);
        for (int i = 0; i < n; i++) bit_time(d[i]);
        if (par_mode == 2'd1 || par_mode == 2'd2) begin
            p = 1'b0;
            for (int i = 0; i < n; i++) p ^= d[i];
            if (par_mode == 2'd2) p = ~p;
            bit_time(p ^ flip);
        end
        bit_time(stopv);
        bit_time(1'b1);
    endtask

    task automatic do_pop();
        pop = 1'b1;
        @(negedge clk);
        pop = 1'b0;
        @(negedge clk);
    endtask

    task automatic head_is(input bit [10:0] exp, input string req);
        chk({rd_brk, rd_ferr, rd_perr, rd_data} == exp, req, "head",
            {rd_brk, rd_ferr, rd_perr, rd_data}, exp);
    endtask

    initial begin
        repeat (4) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R11 reset state
        chk(level == 0, "R11", "level after reset", level, 0);
        chk(!overrun && !data_ready && !data_avail, "R11", "flags after reset",
            {overrun, data_ready, data_avail}, 0);
        repeat (20) @(negedge clk);

        // R2 eight-bit characters, no parity
        send(8'hA5, 1'b1, 1'b0);
        send(8'h3C, 1'b1, 1'b0);
        chk(level == 2, "R2", "two stored", level, 2);
        head_is({3'b000, 8'hA5}, "R2");
        do_pop();
        head_is({3'b000, 8'h3C}, "R6");

        // R1 false start: low for 5 clocks only
        rxd = 1'b0;
        repeat (5) @(negedge clk);
        rxd = 1'b1;
        repeat (64) @(negedge clk);
        chk(level == 1, "R1", "false start stored nothing", level, 1);

        // R3 parity on short characters
        len_code = 2'd0; par_mode = 2'd1;
        send(8'h13, 1'b1, 1'b0);
        head_is({3'b000, 8'h3C}, "R3");
        par_mode = 2'd2;
        send(8'h0A, 1'b1, 1'b1);
        len_code = 2'd2; par_mode = 2'd1;
        send(8'hD5, 1'b1, 1'b1);
        par_mode = 2'd3;
        len_code = 2'd1;
        send(8'hFF, 1'b1, 1'b0);
        do_pop();
        head_is({3'b000, 8'h13}, "R3");
        do_pop();
        head_is({3'b001, 8'h0A}, "R3");
        do_pop();
        head_is({3'b001, 8'h55}, "R3");
        do_pop();
        head_is({3'b000, 8'h3F}, "R2");
        do_pop();

        // R4 framing error, then resync
        len_code = 2'd3; par_mode = 2'd0;
        send(8'h81, 1'b0, 1'b0);
        head_is({3'b010, 8'h81}, "R4");
        send(8'h42, 1'b1, 1'b0);
        do_pop();
        head_is({3'b000, 8'h42}, "R4");
        do_pop();

        // R5 break: long low then high
        rxd = 1'b0;
        repeat (16 * 14) @(negedge clk);
        rxd = 1'b1;
        repeat (40) @(negedge clk);
        chk(level == 1, "R5", "single break entry", level, 1);
        head_is({3'b100, 8'h00}, "R5");
        send(8'h5A, 1'b1, 1'b0);
        do_pop();
        head_is({3'b000, 8'h5A}, "R5");
        do_pop();

        // R6 pop on empty ignored
        do_pop();
        do_pop();
        chk(level == 0, "R6", "pop on empty", level, 0);

        // R9 thresholds while filling, R7 overrun
        thr_sel = 2'd3;
        for (int i = 0; i < 16; i++) begin
            send(8'(i * 7 + 1), 1'b1, 1'b0);
            thr_sel = 2'(i % 4);
        end
        chk(level == 16, "R6", "full", level, 16);
        send(8'hEE, 1'b1, 1'b0);
        chk(overrun == 1'b1, "R7", "overrun set", overrun, 1);
        head_is({3'b000, 8'h01}, "R7");
        repeat (3) @(negedge clk);
        chk(overrun == 1'b1, "R7", "overrun sticky", overrun, 1);
        stat_rd = 1'b1;
        @(negedge clk);
        stat_rd = 1'b0;
        @(negedge clk);
        chk(overrun == 1'b0, "R7", "overrun cleared", overrun, 0);
        for (int s = 0; s < 4; s++) begin
            thr_sel = 2'(s);
            @(negedge clk);
        end
        while (level > 0) do_pop();

        // R10 slower tick pacing
        tick_div = 3;
        repeat (10) @(negedge clk);
        par_mode = 2'd2;
        send(8'hC3, 1'b1, 1'b0);
        send(8'h7E, 1'b1, 1'b1);
        head_is({3'b000, 8'hC3}, "R10");
        do_pop();
        head_is({3'b001, 8'h7E}, "R10");
        do_pop();
        repeat (20) @(negedge clk);

        done = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (190000) @(posedge clk);
        if (!done) begin
            done = 1;
            checks++;
            errors++;
            $display("FAIL watchdog expired actual=running expected=finished");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule